// File: doc/BRIEF.md
# Reset and Boot Configuration Sequencer

This block brings a clocking device out of reset and fills its configuration register file before anything else may run. It merges a chip power-on reset with an active-low external reset pin. The core stays in reset while either one is active. Release is synchronised to the core clock. After release, a first phase always reads a small initial block of words from a one-time-programmable store. One bit of that block then selects the source of the remaining words. Either the same store supplies them, or an external EEPROM does, and its values replace the stored ones. If the EEPROM answers with an error, or does not answer in time, the sequencer raises a sticky error flag and reloads the remaining words from the one-time-programmable store.

Both memories sit behind a plain request/acknowledge read handshake, one word per acknowledge. The host register port stays closed until loading is complete. It then accepts reads and writes. At the same moment a run signal allows the PLLs to attempt lock and enables the clock outputs. From then on, one tracker per PLL flags its outputs as unstable for a programmable number of cycles after each lock rising edge, and while a manual resync request is held and for the same number of cycles after it drops. The reset default of that window is computed from the clock frequency and a settle time of 350 ns.

Top module: `cfg_boot_seq`

## Requirements
- R1: The core is in reset while `por_i` is 1 or while `ext_rst_n_i` is sampled 0. After both have released, the first memory request appears exactly four clock edges after the first edge that samples `ext_rst_n_i` high with `por_i` low.
- R2: From the second cycle of reset on, no memory request is issued, `run_o` is 0, the host port gives no acknowledge and writes have no effect, and every configuration word holds its default. The default is 0, except the window word.
- R3: The first phase reads one-time-programmable words 0 to `N_INIT-1` (default 0 and 1) in ascending address order. Each word is stored at its own index in `cfg_o` (word i at bits i*W and up).
- R4: Bit `SEL_BIT` (default 0) of word `SEL_WORD` (default 1) chooses the source of words `N_INIT` to `N_REGS-1`. A value of 1 selects the EEPROM and a value of 0 selects the one-time-programmable store. Words are requested in ascending order.
- R5: Each word read from the EEPROM replaces the value at its index, and the one-time-programmable store is not read for those words.
- R6: An EEPROM acknowledge with `ee_err_i` high, or `EE_TIMEOUT` cycles without an acknowledge, sets `boot_err_o`. The flag stays set until reset, and words `N_INIT` and up are then reloaded from the one-time-programmable store.
- R7: Before loading completes, a host access gets no acknowledge and changes nothing. After completion, `host_ack_o` is 1 in the cycle after an access. A write updates the addressed word, and a read returns that word on `host_rdata_o`.
- R8: `run_o` rises once all words are loaded, while no memory request is pending, and stays high until reset.
- R9: A rising edge on `pll_lock_i[p]` while running makes `unstable_o[p]` high for exactly W cycles, where W is the window word. A W of 0 gives no flag.
- R10: `unstable_o[p]` is high while `man_sync_i[p]` is held, and for exactly W more cycles after it is first sampled low.
- R11: The window W is word `WIN_WORD` (default 7). Its reset default is ceil(350 ns times the clock frequency), which is 88 at 250 MHz. It can be replaced by loading or by a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_i | input | 1 | Power-on reset, active high |
| ext_rst_n_i | input | 1 | External reset, active low, asynchronous |
| otp_req_o | output | 1 | Read request to the one-time-programmable store |
| otp_addr_o | output | AW | Word address of the store read |
| otp_ack_i | input | 1 | Store read acknowledge, data valid |
| otp_data_i | input | W | Store read data |
| ee_req_o | output | 1 | Read request to the EEPROM reader |
| ee_addr_o | output | AW | Word address of the EEPROM read |
| ee_ack_i | input | 1 | EEPROM read acknowledge |
| ee_data_i | input | W | EEPROM read data |
| ee_err_i | input | 1 | EEPROM read failed, valid with the acknowledge |
| host_valid_i | input | 1 | Host access strobe |
| host_write_i | input | 1 | 1 for write, 0 for read |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | W | Host write data |
| host_ack_o | output | 1 | Access accepted, one cycle after the strobe |
| host_rdata_o | output | W | Read data, valid with the acknowledge |
| cfg_o | output | N_REGS*W | All configuration words, flattened |
| run_o | output | 1 | Loading done: PLL lock attempts and clock outputs enabled |
| boot_err_o | output | 1 | Sticky EEPROM failure flag |
| pll_lock_i | input | N_PLL | Lock status per PLL |
| man_sync_i | input | N_PLL | Manual resync request per PLL |
| unstable_o | output | N_PLL | Outputs of that PLL are settling |

## Verification
The assertions check several rules on every cycle. A power-on reset always holds the core in reset. The two memory sources are never requested together. The timeout counter stays in range. The error flag stays set. A host access before completion is never acknowledged. A lock edge or a held resync opens the unstable window. Only the bench's scenarios can show the rest. These are the address order of the reads, the choice of source by the loaded bit, the EEPROM values replacing stored ones, and the fallback reload after an error or a silent EEPROM. They also cover the exact latency out of reset, the host data round trip, and the exact length of the window after a lock edge and after a released resync.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_INIT,
        LD_PICK,
        LD_OTP,
        LD_EE,
        LD_DONE
    } ld_state_e;

    typedef struct packed {
        logic lock_rise;
        logic sync_hold;
        logic sync_fall;
    } sync_evt_t;

    function automatic int settle_cycles(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/cbs_rst_sync.sv
module cbs_rst_sync (
    input  logic clk,
    input  logic por_i,
    input  logic ext_rst_n_i,
    output logic rst_o
);
    logic [1:0] sync_q;
    logic       rst_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], ext_rst_n_i};
        end
        rst_q <= por_i | ~sync_q[1];
    end

    assign rst_o = rst_q;

    // R1: a power-on reset always forces the core reset on the next edge
    a_r1_por_holds_reset: assert property (@(posedge clk) por_i |=> rst_o);

endmodule

// File: rtl/cbs_loader.sv
module cbs_loader
    import cbs_pkg::*;
#(
    parameter int N_REGS     = 8,
    parameter int W          = 8,
    parameter int N_INIT     = 2,
    parameter int SEL_WORD   = 1,
    parameter int SEL_BIT    = 0,
    parameter int WIN_WORD   = 7,
    parameter int WIN_DEF    = 88,
    parameter int EE_TIMEOUT = 100,
    localparam int AW = $clog2(N_REGS),
    localparam int TW = $clog2(EE_TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_i,
    output logic              otp_req_o,
    output logic [AW-1:0]     otp_addr_o,
    input  logic              otp_ack_i,
    input  logic [W-1:0]      otp_data_i,
    output logic              ee_req_o,
    output logic [AW-1:0]     ee_addr_o,
    input  logic              ee_ack_i,
    input  logic [W-1:0]      ee_data_i,
    input  logic              ee_err_i,
    input  logic              host_valid_i,
    input  logic              host_write_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [W-1:0]      host_wdata_i,
    output logic              host_ack_o,
    output logic [W-1:0]      host_rdata_o,
    output logic [N_REGS*W-1:0] cfg_o,
    output logic [W-1:0]      win_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [AW-1:0] LAST_INIT = AW'(N_INIT - 1);
    localparam logic [AW-1:0] LAST_WORD = AW'(N_REGS - 1);
    localparam logic [AW-1:0] FIRST_REST = AW'(N_INIT);
    localparam logic [TW-1:0] TMO_LAST  = TW'(EE_TIMEOUT - 1);

    ld_state_e         state_q;
    logic [AW-1:0]     idx_q;
    logic [TW-1:0]     tmo_q;
    logic [W-1:0]      regs_q [N_REGS];
    logic              err_q;
    logic              ack_q;
    logic [W-1:0]      rdata_q;

    logic              otp_take;
    logic              ee_take;
    logic              ee_fail;
    logic              done;
    logic              host_wr;

    assign otp_req_o  = (state_q == LD_INIT) || (state_q == LD_OTP);
    assign ee_req_o   = (state_q == LD_EE);
    assign otp_addr_o = idx_q;
    assign ee_addr_o  = idx_q;
    assign otp_take   = otp_req_o && otp_ack_i;
    assign ee_take    = ee_req_o && ee_ack_i && !ee_err_i;
    assign ee_fail    = ee_req_o && ((ee_ack_i && ee_err_i) || (!ee_ack_i && tmo_q == TMO_LAST));
    assign done       = (state_q == LD_DONE);
    assign host_wr    = done && host_valid_i && host_write_i;

    // sequencing of the two load phases
    always_ff @(posedge clk) begin
        if (rst_i) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
            tmo_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                LD_IDLE: begin
                    state_q <= LD_INIT;
                    idx_q   <= '0;
                end
                LD_INIT: if (otp_take) begin
                    if (idx_q == LAST_INIT) state_q <= LD_PICK;
                    idx_q <= idx_q + 1'b1;
                end
                LD_PICK: begin
                    idx_q   <= FIRST_REST;
                    tmo_q   <= '0;
                    state_q <= regs_q[SEL_WORD][SEL_BIT] ? LD_EE : LD_OTP;
                end
                LD_OTP: if (otp_take) begin
                    if (idx_q == LAST_WORD) state_q <= LD_DONE;
                    else                    idx_q   <= idx_q + 1'b1;
                end
                LD_EE: begin
                    if (ee_fail) begin
                        err_q   <= 1'b1;
                        idx_q   <= FIRST_REST;
                        state_q <= LD_OTP;
                    end else if (ee_take) begin
                        tmo_q <= '0;
                        if (idx_q == LAST_WORD) state_q <= LD_DONE;
                        else                    idx_q   <= idx_q + 1'b1;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                LD_DONE: state_q <= LD_DONE;
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    // register file: defaults, loader writes, host writes
    always_ff @(posedge clk) begin
        if (rst_i) begin
            for (int i = 0; i < N_REGS; i++) begin
                regs_q[i] <= (i == WIN_WORD) ? W'(WIN_DEF) : '0;
            end
        end else if (otp_take) begin
            regs_q[idx_q] <= otp_data_i;
        end else if (ee_take) begin
            regs_q[idx_q] <= ee_data_i;
        end else if (host_wr) begin
            regs_q[host_addr_i] <= host_wdata_i;
        end
    end

    // host port, closed until loading completes
    always_ff @(posedge clk) begin
        if (rst_i) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= host_valid_i && done;
            if (host_valid_i && done && !host_write_i) rdata_q <= regs_q[host_addr_i];
        end
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_cfg
        assign cfg_o[g*W +: W] = regs_q[g];
    end

    assign win_o        = regs_q[WIN_WORD];
    assign done_o       = done;
    assign err_o        = err_q;
    assign host_ack_o   = ack_q;
    assign host_rdata_o = rdata_q;

    // R4: never both sources at once
    a_r4_one_source: assert property (@(posedge clk) disable iff (rst_i)
        !(otp_req_o && ee_req_o));
    // R6: wait counter never passes its limit
    a_r6_tmo_bound: assert property (@(posedge clk) disable iff (rst_i)
        tmo_q <= TMO_LAST);
    // R6: error flag is sticky until reset
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst_i)
        err_o |=> err_o);
    // R7: host access before completion is never acknowledged
    a_r7_host_blocked: assert property (@(posedge clk) disable iff (rst_i)
        (host_valid_i && !done_o) |=> !host_ack_o);
    // R8: completion is permanent until reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst_i)
        done_o |=> done_o);

endmodule

// File: rtl/cbs_resync.sv
module cbs_resync
    import cbs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_i,
    input  logic         run_i,
    input  logic         lock_i,
    input  logic         sync_i,
    input  logic [W-1:0] win_i,
    output logic         unstable_o
);
    sync_evt_t    ev;
    logic         lock_q;
    logic         sync_q;
    logic [W-1:0] cnt_q;

    always_comb begin
        ev.lock_rise = lock_i & ~lock_q;
        ev.sync_hold = sync_i;
        ev.sync_fall = ~sync_i & sync_q;
    end

    always_ff @(posedge clk) begin
        if (rst_i || !run_i) begin
            lock_q <= 1'b0;
            sync_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            lock_q <= lock_i;
            sync_q <= sync_i;
            if (|ev)              cnt_q <= win_i;
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign unstable_o = (cnt_q != '0);

    // R9: a lock edge opens the window
    a_r9_lock_opens_window: assert property (@(posedge clk) disable iff (rst_i || !run_i)
        ($rose(lock_i) && win_i != '0) |=> unstable_o);
    // R10: a held resync request keeps the outputs flagged
    a_r10_sync_holds_window: assert property (@(posedge clk) disable iff (rst_i || !run_i)
        (sync_i && win_i != '0) |=> unstable_o);

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cbs_pkg::*;
#(
    parameter int N_REGS     = 8,
    parameter int W          = 8,
    parameter int N_INIT     = 2,
    parameter int SEL_WORD   = 1,
    parameter int SEL_BIT    = 0,
    parameter int WIN_WORD   = 7,
    parameter int EE_TIMEOUT = 100,
    parameter int N_PLL      = 2,
    parameter int CLK_MHZ    = 250,
    parameter int SETTLE_NS  = 350,
    localparam int AW = $clog2(N_REGS),
    localparam int WIN_DEF = settle_cycles(SETTLE_NS, CLK_MHZ)
) (
    input  logic                clk,
    input  logic                por_i,
    input  logic                ext_rst_n_i,
    output logic                otp_req_o,
    output logic [AW-1:0]       otp_addr_o,
    input  logic                otp_ack_i,
    input  logic [W-1:0]        otp_data_i,
    output logic                ee_req_o,
    output logic [AW-1:0]       ee_addr_o,
    input  logic                ee_ack_i,
    input  logic [W-1:0]        ee_data_i,
    input  logic                ee_err_i,
    input  logic                host_valid_i,
    input  logic                host_write_i,
    input  logic [AW-1:0]       host_addr_i,
    input  logic [W-1:0]        host_wdata_i,
    output logic                host_ack_o,
    output logic [W-1:0]        host_rdata_o,
    output logic [N_REGS*W-1:0] cfg_o,
    output logic                run_o,
    output logic                boot_err_o,
    input  logic [N_PLL-1:0]    pll_lock_i,
    input  logic [N_PLL-1:0]    man_sync_i,
    output logic [N_PLL-1:0]    unstable_o
);
    logic         core_rst;
    logic         done;
    logic [W-1:0] win;

    cbs_rst_sync u_rst (
        .clk         (clk),
        .por_i       (por_i),
        .ext_rst_n_i (ext_rst_n_i),
        .rst_o       (core_rst)
    );

    cbs_loader #(
        .N_REGS     (N_REGS),
        .W          (W),
        .N_INIT     (N_INIT),
        .SEL_WORD   (SEL_WORD),
        .SEL_BIT    (SEL_BIT),
        .WIN_WORD   (WIN_WORD),
        .WIN_DEF    (WIN_DEF),
        .EE_TIMEOUT (EE_TIMEOUT)
    ) u_load (
        .clk          (clk),
        .rst_i        (core_rst),
        .otp_req_o    (otp_req_o),
        .otp_addr_o   (otp_addr_o),
        .otp_ack_i    (otp_ack_i),
        .otp_data_i   (otp_data_i),
        .ee_req_o     (ee_req_o),
        .ee_addr_o    (ee_addr_o),
        .ee_ack_i     (ee_ack_i),
        .ee_data_i    (ee_data_i),
        .ee_err_i     (ee_err_i),
        .host_valid_i (host_valid_i),
        .host_write_i (host_write_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_ack_o   (host_ack_o),
        .host_rdata_o (host_rdata_o),
        .cfg_o        (cfg_o),
        .win_o        (win),
        .done_o       (done),
        .err_o        (boot_err_o)
    );

    assign run_o = done;

    for (genvar p = 0; p < N_PLL; p++) begin : g_pll
        cbs_resync #(.W(W)) u_resync (
            .clk        (clk),
            .rst_i      (core_rst),
            .run_i      (done),
            .lock_i     (pll_lock_i[p]),
            .sync_i     (man_sync_i[p]),
            .win_i      (win),
            .unstable_o (unstable_o[p])
        );
    end

    // R2: while reset is held over two edges, nothing runs
    a_r2_no_run_in_reset: assert property (@(posedge clk) disable iff (!core_rst)
        $past(core_rst) |-> !run_o && !host_ack_o);

endmodule

// File: tb/cfg_boot_seq_bench.sv
module cfg_boot_seq_bench;
    localparam int NR = 8;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          ext_n = 1'b1;
    logic          otp_req, otp_ack = 1'b0;
    logic [2:0]    otp_addr;
    logic [W-1:0]  otp_data = '0;
    logic          ee_req, ee_ack = 1'b0, ee_err = 1'b0;
    logic [2:0]    ee_addr;
    logic [W-1:0]  ee_data = '0;
    logic          h_valid = 1'b0, h_write = 1'b0;
    logic [2:0]    h_addr = '0;
    logic [W-1:0]  h_wdata = '0;
    logic          h_ack;
    logic [W-1:0]  h_rdata;
    logic [NR*W-1:0] cfg;
    logic          run, berr;
    logic [1:0]    lock = 2'b00, msync = 2'b00;
    logic [1:0]    unst;

    int n_chk = 0;
    int n_fail = 0;
    bit sel_cfg = 1'b0;
    int ee_mode = 0;           // 0 normal, 1 error at word 5, 2 silent
    int otp_n = 0;
    int otp_log [0:255];

    always #2 clk = ~clk;

    cfg_boot_seq u_cfg_boot_seq (
        .clk (clk), .por_i (por), .ext_rst_n_i (ext_n),
        .otp_req_o (otp_req), .otp_addr_o (otp_addr), .otp_ack_i (otp_ack), .otp_data_i (otp_data),
        .ee_req_o (ee_req), .ee_addr_o (ee_addr), .ee_ack_i (ee_ack), .ee_data_i (ee_data), .ee_err_i (ee_err),
        .host_valid_i (h_valid), .host_write_i (h_write), .host_addr_i (h_addr), .host_wdata_i (h_wdata),
        .host_ack_o (h_ack), .host_rdata_o (h_rdata), .cfg_o (cfg), .run_o (run), .boot_err_o (berr),
        .pll_lock_i (lock), .man_sync_i (msync), .unstable_o (unst)
    );

    function automatic logic [W-1:0] otp_word(input int a);
        if (a == 1) return {7'd0, sel_cfg};
        if (a == 7) return 8'd5;
        return 8'h10 + W'(a);
    endfunction

    function automatic logic [W-1:0] ee_word(input int a);
        if (a == 7) return 8'd6;
        return 8'hA0 + W'(a);
    endfunction

    function automatic int word(input int i);
        return int'(cfg[i*W +: W]);
    endfunction

    // one-time-programmable store model
    initial forever begin
        @(negedge clk);
        if (otp_ack) otp_ack = 1'b0;
        else if (otp_req) begin
            otp_data = otp_word(int'(otp_addr));
            otp_log[otp_n[7:0]] = int'(otp_addr);
            otp_n = otp_n + 1;
            otp_ack = 1'b1;
        end
    end

    // EEPROM reader model
    initial forever begin
        @(negedge clk);
        if (ee_ack) begin ee_ack = 1'b0; ee_err = 1'b0; end
        else if (ee_req && ee_mode != 2) begin
            ee_data = ee_word(int'(ee_addr));
            ee_err  = (ee_mode == 1 && ee_addr == 3'd5);
            ee_ack  = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic hold_reset();
        por = 1'b1; ext_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic boot(output bit ok);
        por = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 3000 && !ok; i++) begin
            @(negedge clk);
            ok = run;
        end
    endtask

    task automatic t_reset();
        hold_reset();
        chk(run == 1'b0, "R2 run low in reset", run, 0);
        chk(word(7) == 88, "R11 window default", word(7), 88);
        chk(word(0) == 0, "R2 word0 default", word(0), 0);
        h_valid = 1'b1; h_write = 1'b1; h_addr = 3'd0; h_wdata = 8'hFF;
        @(negedge clk);
        chk(h_ack == 1'b0, "R2 host ignored in reset", h_ack, 0);
        h_valid = 1'b0;
        @(negedge clk);
        chk(word(0) == 0, "R2 host write no effect in reset", word(0), 0);
        por = 1'b0; ext_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(otp_req == 1'b0, "R1 ext reset holds core", otp_req, 0);
        ext_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(otp_req == 1'b0, "R1 still in reset after 3 edges", otp_req, 0);
        @(negedge clk);
        chk(otp_req == 1'b1, "R1 first request on 4th edge", otp_req, 1);
    endtask

    task automatic t_boot_otp();
        bit ok;
        int base;
        hold_reset();
        sel_cfg = 1'b0; ee_mode = 0;
        base = otp_n;
        por = 1'b0;
        repeat (8) @(negedge clk);
        h_valid = 1'b1; h_write = 1'b1; h_addr = 3'd3; h_wdata = 8'hFF;
        @(negedge clk);
        chk(h_ack == 1'b0, "R7 no ack while loading", h_ack, 0);
        chk(run == 1'b0, "R8 run low while loading", run, 0);
        h_valid = 1'b0;
        boot(ok);
        chk(ok, "R8 run rises after load", run, 1);
        chk(otp_req == 1'b0 && ee_req == 1'b0, "R8 no request pending at run", otp_req, 0);
        chk(otp_n - base == 8, "R4 all words from store", otp_n - base, 8);
        for (int i = 0; i < 8; i++)
            chk(otp_log[(base + i) % 256] == i, "R3 ascending read order", otp_log[(base + i) % 256], i);
        for (int i = 0; i < 8; i++)
            chk(word(i) == int'(otp_word(i)), "R3 stored word", word(i), int'(otp_word(i)));
        chk(word(3) == 8'h13, "R7 write while loading had no effect", word(3), 8'h13);
        chk(berr == 1'b0, "R6 no error on clean boot", berr, 0);
    endtask

    task automatic t_boot_ee();
        bit ok;
        int base;
        hold_reset();
        sel_cfg = 1'b1; ee_mode = 0;
        base = otp_n;
        boot(ok);
        chk(ok, "R8 run after EEPROM boot", run, 1);
        chk(otp_n - base == 2, "R4 only initial block from store", otp_n - base, 2);
        chk(word(1) == 1, "R4 select word kept", word(1), 1);
        for (int i = 2; i < 8; i++)
            chk(word(i) == int'(ee_word(i)), "R5 EEPROM value replaces", word(i), int'(ee_word(i)));
        chk(berr == 1'b0, "R6 no error", berr, 0);
    endtask

    task automatic t_ee_fail(input int mode);
        bit ok;
        hold_reset();
        chk(berr == 1'b0, "R6 flag cleared by reset", berr, 0);
        sel_cfg = 1'b1; ee_mode = mode;
        boot(ok);
        chk(ok, "R6 boot completes after failure", run, 1);
        chk(berr == 1'b1, "R6 error flag set", berr, 1);
        for (int i = 2; i < 8; i++)
            chk(word(i) == int'(otp_word(i)), "R6 store values kept", word(i), int'(otp_word(i)));
        repeat (5) @(negedge clk);
        chk(berr == 1'b1, "R6 flag sticky", berr, 1);
        ee_mode = 0;
    endtask

    task automatic t_host();
        h_valid = 1'b1; h_write = 1'b1; h_addr = 3'd4; h_wdata = 8'h5A;
        @(negedge clk);
        chk(h_ack == 1'b1, "R7 write acknowledged", h_ack, 1);
        chk(word(4) == 8'h5A, "R7 write updates word", word(4), 8'h5A);
        h_write = 1'b0;
        @(negedge clk);
        chk(h_ack == 1'b1 && h_rdata == 8'h5A, "R7 read returns word", h_rdata, 8'h5A);
        h_valid = 1'b0;
        @(negedge clk);
        chk(h_ack == 1'b0, "R7 ack drops with strobe", h_ack, 0);
    endtask

    task automatic t_resync();
        bit ok;
        int cnt;
        hold_reset();
        sel_cfg = 1'b0; ee_mode = 0; lock = 2'b00; msync = 2'b00;
        boot(ok);
        chk(unst == 2'b00, "R9 no flag before any event", unst, 0);
        chk(word(7) == 5, "R11 window loaded", word(7), 5);
        lock[0] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); cnt += int'(unst[0]); end
        chk(cnt == 5, "R9 lock window length", cnt, 5);
        chk(unst[1] == 1'b0, "R9 other PLL untouched", unst[1], 0);
        t_host();
        h_valid = 1'b1; h_write = 1'b1; h_addr = 3'd7; h_wdata = 8'd3;
        @(negedge clk);
        h_valid = 1'b0;
        msync[1] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            cnt += int'(unst[1]);
            if (i == 3) msync[1] = 1'b0;
        end
        chk(cnt == 7, "R10 hold plus window", cnt, 7);
        chk(cnt == 7, "R11 window from host write", cnt, 7);
        lock[0] = 1'b0;
        @(negedge clk);
        lock[0] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += int'(unst[0]); end
        chk(cnt == 3, "R9 re-lock window", cnt, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_boot_otp();
        t_boot_ee();
        t_ee_fail(1);
        t_ee_fail(2);
        t_resync();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule